// File: doc/BRIEF.md
# Interrupt Request Hub with Non-Maskable Routing

The hub gathers request lines from on-chip peripherals and presents them to the processor as a 22-bit interrupt vector, one bit per interrupt number 0 to 21. Numbers 3 and 4 are held back and never fire. Number 8 is shared by three general-purpose I/O port groups, and the hub ORs their requests onto that line. Every other number carries a single peripheral. For each number, software can read an identity word that shows which of the sources behind that number is currently requesting.

A control word picks one interrupt number and copies its line onto a separate non-maskable interrupt output. The same control word holds a test-mode switch, and that switch is guarded by a three-byte unlock sequence written to a key register. While test mode is on, the peripheral requests are cut off. The interrupt vector then takes its value from a software-written override word, so that interrupt handling can be exercised without the peripherals.

Software reaches the hub through a simple register bus with a byte address, write strobe, write data and registered read data. The vector and the non-maskable output are both registered and update in the same cycle.

Top module: `irq_hub`

## Requirements
- R1: After reset, `irq_o` is 0, `nmi_o` is 0, the control word (0x80), override word (0x84) and key register (0x88) all read 0, and the hub is locked.
- R2: In normal mode, for each non-reserved interrupt number n other than 8, `irq_o[n]` equals `src_req[n]` as it was one clock edge earlier.
- R3: `irq_o[8]` is the OR of `grp_req[2:0]` one edge later, and `src_req[8]` has no effect on any output or register.
- R4: Lines 3 and 4 never assert in any mode, their identity words read 0, and `src_req[3]` and `src_req[4]` have no effect.
- R5: The identity word of number n is at byte offset 4*n. Bit 0 shows `src_req[n]` and bits 31:1 read 0. For number 8, bits 2:0 show `grp_req[0]`, `grp_req[1]` and `grp_req[2]`.
- R6: Bits 4:0 of the control word at 0x80 select an interrupt number. `nmi_o` equals the `irq_o` bit that the select held at the previous edge, and it updates in the same cycle as `irq_o`.
- R7: A select value above 21, or equal to 3 or 4, keeps `nmi_o` low.
- R8: Writing the low bytes 0x59, 0x16 and 0x88 in that order to the key register at 0x88 unlocks the hub, and the key register then reads 1 (it reads 0 while locked). A wrong byte restarts the sequence, and a 0x59 counts as a new first byte. Writes to other offsets in the middle of the sequence do not disturb it. Once unlocked, writing any byte other than the three key values locks the hub again.
- R9: Bit 7 of the control word is the test-mode enable. A write changes it only while the hub is unlocked, but bits 4:0 always take the written value.
- R10: In test mode, `irq_o` equals the 22-bit override word at 0x84 one edge later, whatever `src_req` and `grp_req` are doing. The override word reads back with bits 3 and 4 cleared.
- R11: Read data appears on `bus_rdata` after the first clock edge following the presented address, and any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_req | input | 22 | Peripheral request per interrupt number |
| grp_req | input | 3 | Requests from I/O port groups A, B, C (shared line 8) |
| irq_o | output | 22 | Interrupt vector to the processor |
| nmi_o | output | 1 | Non-maskable interrupt |

## Verification
A corrupted select or test-mode bit shows on the very next edge. `nmi_o` then parts from the `irq_o` bit it should mirror, or `irq_o` stops following the inputs and shows the override word instead. A fault in the key state machine surfaces when the key register is read back a cycle later. It also shows as a test-mode write that takes effect, or fails to, which the control word readback reveals one cycle after that. Sweeping every line, every port-group pattern and all 32 select codes makes a wrong routing or mask bit appear as a mismatched vector bit within one cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NUM_IRQ    = 22;
  localparam int SHARED_IRQ = 8;
  localparam int GRP_W      = 3;
  localparam int SEL_W      = 5;
  localparam int AW         = 8;
  localparam int DW         = 32;
  localparam logic [NUM_IRQ-1:0] RSV_MASK = 22'h000018;
  localparam logic [AW-1:0] CTRL_OFS  = 8'h80;
  localparam logic [AW-1:0] OVR_OFS   = 8'h84;
  localparam logic [AW-1:0] KEY_OFS   = 8'h88;
  localparam logic [7:0] KEY_A = 8'h59;
  localparam logic [7:0] KEY_B = 8'h16;
  localparam logic [7:0] KEY_C = 8'h88;
  localparam int TM_BIT = 7;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_GOT_A  = 2'd1,
    KS_GOT_B  = 2'd2,
    KS_OPEN   = 2'd3
  } key_state_e;
endpackage

// File: rtl/irq_hub_key.sv
module irq_hub_key
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  key_state_e state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (key_wr) begin
      unique case (state_q)
        KS_LOCKED: state_nxt = (key_byte == KEY_A) ? KS_GOT_A : KS_LOCKED;
        KS_GOT_A:  state_nxt = (key_byte == KEY_B) ? KS_GOT_B :
                               (key_byte == KEY_A) ? KS_GOT_A : KS_LOCKED;
        KS_GOT_B:  state_nxt = (key_byte == KEY_C) ? KS_OPEN :
                               (key_byte == KEY_A) ? KS_GOT_A : KS_LOCKED;
        KS_OPEN:   state_nxt = (key_byte == KEY_A || key_byte == KEY_B ||
                                key_byte == KEY_C) ? KS_OPEN : KS_LOCKED;
        default:   state_nxt = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_nxt;
  end

  assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/irq_hub_route.sv
module irq_hub_route
  import irq_hub_pkg::*;
#(
  parameter int NIRQ = NUM_IRQ,
  parameter int SHR  = SHARED_IRQ,
  parameter int GW   = GRP_W,
  parameter int SW   = SEL_W,
  parameter logic [NIRQ-1:0] RSV = RSV_MASK
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] src_req,
  input  logic [GW-1:0]   grp_req,
  input  logic            test_mode,
  input  logic [NIRQ-1:0] ovr_word,
  input  logic [SW-1:0]   nmi_sel,
  output logic [NIRQ-1:0] irq_o,
  output logic            nmi_o
);
  logic [NIRQ-1:0] live_line, line_nxt;
  logic            nmi_nxt;

  for (genvar n = 0; n < NIRQ; n++) begin : g_line
    if (RSV[n]) begin : g_rsv
      assign live_line[n] = 1'b0;
    end else if (n == SHR) begin : g_shared
      assign live_line[n] = |grp_req;
    end else begin : g_single
      assign live_line[n] = src_req[n];
    end
  end

  always_comb begin
    line_nxt = test_mode ? (ovr_word & ~RSV) : live_line;
    nmi_nxt  = 1'b0;
    if (int'(nmi_sel) < NIRQ) nmi_nxt = line_nxt[nmi_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= '0;
      nmi_o <= 1'b0;
    end else begin
      irq_o <= line_nxt;
      nmi_o <= nmi_nxt;
    end
  end
endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux
  import irq_hub_pkg::*;
#(
  parameter int NIRQ = NUM_IRQ,
  parameter int SHR  = SHARED_IRQ,
  parameter int GW   = GRP_W,
  parameter int SW   = SEL_W,
  parameter logic [NIRQ-1:0] RSV = RSV_MASK
)(
  input  logic [AW-1:0]   addr,
  input  logic [NIRQ-1:0] src_req,
  input  logic [GW-1:0]   grp_req,
  input  logic [SW-1:0]   nmi_sel,
  input  logic            test_mode,
  input  logic [NIRQ-1:0] ovr_word,
  input  logic            unlocked,
  output logic [DW-1:0]   rd_data
);
  localparam int IDX_W = $clog2(NIRQ);
  localparam int ID_W  = (GW > 1) ? GW : 1;

  logic [ID_W-1:0] id_word [NIRQ];
  logic [AW-3:0]   word_idx;

  for (genvar n = 0; n < NIRQ; n++) begin : g_id
    if (RSV[n]) begin : g_rsv
      assign id_word[n] = '0;
    end else if (n == SHR) begin : g_shared
      assign id_word[n] = grp_req;
    end else begin : g_single
      assign id_word[n] = {{(ID_W-1){1'b0}}, src_req[n]};
    end
  end

  assign word_idx = addr[AW-1:2];

  always_comb begin
    rd_data = '0;
    if (addr[1:0] == 2'b00) begin
      if (int'(word_idx) < NIRQ) begin
        rd_data[ID_W-1:0] = id_word[word_idx[IDX_W-1:0]];
      end else if (addr == CTRL_OFS) begin
        rd_data[SW-1:0]  = nmi_sel;
        rd_data[TM_BIT]  = test_mode;
      end else if (addr == OVR_OFS) begin
        rd_data[NIRQ-1:0] = ovr_word;
      end else if (addr == KEY_OFS) begin
        rd_data[0] = unlocked;
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0] src_req,
  input  logic [GRP_W-1:0]   grp_req,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               nmi_o
);
  logic [SEL_W-1:0]   sel_q, sel_nxt;
  logic               tm_q, tm_nxt;
  logic [NUM_IRQ-1:0] ovr_q, ovr_nxt;
  logic [DW-1:0]      rd_nxt;
  logic               unlocked;
  logic               ctrl_wr, ovr_wr, key_wr;

  assign ctrl_wr = bus_we && (bus_addr == CTRL_OFS);
  assign ovr_wr  = bus_we && (bus_addr == OVR_OFS);
  assign key_wr  = bus_we && (bus_addr == KEY_OFS);

  always_comb begin
    sel_nxt = sel_q;
    tm_nxt  = tm_q;
    ovr_nxt = ovr_q;
    if (ctrl_wr) begin
      sel_nxt = bus_wdata[SEL_W-1:0];
      if (unlocked) tm_nxt = bus_wdata[TM_BIT];
    end
    if (ovr_wr) ovr_nxt = bus_wdata[NUM_IRQ-1:0] & ~RSV_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      tm_q      <= 1'b0;
      ovr_q     <= '0;
      bus_rdata <= '0;
    end else begin
      sel_q     <= sel_nxt;
      tm_q      <= tm_nxt;
      ovr_q     <= ovr_nxt;
      bus_rdata <= rd_nxt;
    end
  end

  irq_hub_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (bus_wdata[7:0]),
    .unlocked (unlocked)
  );

  irq_hub_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .grp_req   (grp_req),
    .test_mode (tm_q),
    .ovr_word  (ovr_q),
    .nmi_sel   (sel_q),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  irq_hub_rdmux u_rdmux (
    .addr      (bus_addr),
    .src_req   (src_req),
    .grp_req   (grp_req),
    .nmi_sel   (sel_q),
    .test_mode (tm_q),
    .ovr_word  (ovr_q),
    .unlocked  (unlocked),
    .rd_data   (rd_nxt)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_we,
  input logic [DW-1:0]      bus_rdata,
  input logic [GRP_W-1:0]   grp_req,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic               nmi_o,
  input logic [SEL_W-1:0]   sel_q,
  input logic               tm_q,
  input logic [NUM_IRQ-1:0] ovr_q,
  input logic               unlocked
);
  // R4: held-back lines never assert
  a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[3] == 1'b0) && (irq_o[4] == 1'b0));

  // R6: nmi mirrors the selected vector bit
  a_r6_nmi_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) < NUM_IRQ) |=> (nmi_o == irq_o[$past(sel_q)]));

  // R7: out-of-range select keeps nmi low
  a_r7_nmi_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_q) >= NUM_IRQ) |=> !nmi_o);

  // R9: test-mode bit cannot move while locked
  a_r9_tm_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(tm_q));

  // R10: test mode drives the vector from the override word
  a_r10_override: assert property (@(posedge clk) disable iff (!rst_n)
    tm_q |=> (irq_o == ($past(ovr_q) & ~RSV_MASK)));

  // R3: shared line is the OR of the port groups
  a_r3_shared_or: assert property (@(posedge clk) disable iff (!rst_n)
    !tm_q |=> (irq_o[SHARED_IRQ] == |$past(grp_req)));

  // R8: key register readback
  a_r8_key_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == KEY_OFS) |=> (bus_rdata == {{(DW-1){1'b0}}, $past(unlocked)}));

  // R11: unmapped offsets read zero
  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > KEY_OFS) |=> (bus_rdata == '0));

  logic unused_we;
  assign unused_we = bus_we;
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .grp_req   (grp_req),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o),
  .sel_q     (sel_q),
  .tm_q      (tm_q),
  .ovr_q     (ovr_q),
  .unlocked  (unlocked)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [21:0] src_req = '0;
  logic [2:0]  grp_req = '0;
  logic [21:0] irq_o;
  logic        nmi_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [21:0] RSV = 22'h000018;

  always #10 clk = ~clk;

  irq_hub uut (.*);

  function automatic logic [21:0] exp_vec(logic [21:0] s, logic [2:0] g);
    logic [21:0] v;
    v = s & ~(RSV | 22'h000100);
    v[8] = |g;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFC;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle(logic [21:0] s, logic [2:0] g);
    @(negedge clk);
    src_req = s; grp_req = g;
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [21:0] pat;
    logic        exp_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {10'b0, irq_o}, 32'h0);
    check("R1 nmi", {31'b0, nmi_o}, 32'h0);
    rd(8'h80, d); check("R1 ctrl", d, 32'h0);
    rd(8'h84, d); check("R1 ovr", d, 32'h0);
    rd(8'h88, d); check("R1 key", d, 32'h0);

    // R2 R3 R4 R5 line sweep
    for (int n = 0; n < 22; n++) begin
      settle(22'h1 << n, 3'b000);
      check("R2/R3/R4 vector", {10'b0, irq_o}, {10'b0, exp_vec(22'h1 << n, 3'b000)});
      rd(8'(4 * n), d);
      check("R5 identity", d, (n == 3 || n == 4 || n == 8) ? 32'h0 : 32'h1);
    end
    for (int g = 0; g < 8; g++) begin
      settle(22'h3FFFFF, 3'(g));
      check("R3 shared line", {31'b0, irq_o[8]}, {31'b0, (g != 0)});
      check("R4 reserved", {30'b0, irq_o[4:3]}, 32'h0);
      rd(8'h20, d); check("R5 group identity", d, 32'(g));
    end
    rd(8'h0C, d); check("R4 identity3", d, 32'h0);
    rd(8'h10, d); check("R4 identity4", d, 32'h0);

    // R6 R7 select sweep
    for (int s = 0; s < 32; s++) begin
      wr(8'h80, 32'(s));
      pat = 22'h2AAAAA ^ {22{s[0]}};
      settle(pat, 3'(s));
      exp_n = (s < 22) ? exp_vec(pat, 3'(s))[s] : 1'b0;
      check("R6/R7 nmi", {31'b0, nmi_o}, {31'b0, exp_n});
      settle(22'h3FFFFF, 3'b111);
      exp_n = (s < 22 && s != 3 && s != 4);
      check("R6/R7 nmi all", {31'b0, nmi_o}, {31'b0, exp_n});
    end

    // R11 unmapped
    rd(8'h58, d); check("R11 unmapped 58", d, 32'h0);
    rd(8'h8C, d); check("R11 unmapped 8C", d, 32'h0);
    rd(8'hFC, d); check("R11 unmapped FC", d, 32'h0);
    rd(8'h81, d); check("R11 unaligned", d, 32'h0);

    // R9 locked write does not set test mode
    wr(8'h80, 32'h85);
    rd(8'h80, d); check("R9 locked write", d, 32'h05);
    // R8 wrong order
    wr(8'h88, 32'h59); wr(8'h88, 32'h88);
    rd(8'h88, d); check("R8 wrong order", d, 32'h0);
    wr(8'h88, 32'h59); wr(8'h88, 32'h16); wr(8'h88, 32'h59);
    wr(8'h88, 32'h16);
    rd(8'h88, d); check("R8 partial", d, 32'h0);
    wr(8'h88, 32'h88);
    rd(8'h88, d); check("R8 restart unlock", d, 32'h1);
    wr(8'h88, 32'h16);
    rd(8'h88, d); check("R8 key value keeps open", d, 32'h1);
    wr(8'h88, 32'h00);
    rd(8'h88, d); check("R8 relock", d, 32'h0);
    // interleaved write
    wr(8'h88, 32'h59); wr(8'h84, 32'h0); wr(8'h88, 32'h16); wr(8'h88, 32'h88);
    rd(8'h88, d); check("R8 interleaved", d, 32'h1);

    // R9 R10 test mode
    wr(8'h80, 32'h85);
    rd(8'h80, d); check("R9 unlocked write", d, 32'h85);
    wr(8'h84, 32'h3FFFFF);
    rd(8'h84, d); check("R10 override readback", d, 32'h3FFFE7);
    settle(22'h0, 3'b000);
    check("R10 override vector", {10'b0, irq_o}, 32'h3FFFE7);
    check("R6 nmi from override", {31'b0, nmi_o}, 32'h1);
    wr(8'h84, 32'h000100);
    settle(22'h3FFFFF, 3'b111);
    check("R10 peripherals blocked", {10'b0, irq_o}, 32'h000100);
    check("R6 nmi blocked", {31'b0, nmi_o}, 32'h0);
    wr(8'h88, 32'h42);
    wr(8'h80, 32'h00);
    rd(8'h80, d); check("R9 relocked keeps tm", d, 32'h80);
    check("R10 still override", {10'b0, irq_o}, 32'h000100);
    wr(8'h88, 32'h59); wr(8'h88, 32'h16); wr(8'h88, 32'h88);
    wr(8'h80, 32'h00);
    rd(8'h80, d); check("R9 tm cleared", d, 32'h0);
    settle(22'h155555, 3'b010);
    check("R2 normal again", {10'b0, irq_o}, {10'b0, exp_vec(22'h155555, 3'b010)});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule